// File: doc/BRIEF.md
# Serial EEPROM Target Emulator

This block sits on a two-wire serial bus as a target and behaves like a byte-addressed serial EEPROM of up to 2 Mbit. It samples the clock and data lines with the system clock, finds START and STOP conditions, decodes a control byte, takes a two-byte memory offset, and then either accepts write data or streams read data. The data line is driven open-drain: the block only ever pulls it low.

A byte address is 19 bits wide. The top bit is held by a strap input, so two of these blocks can share one bus and appear as one contiguous memory. Writes are held in a one-page staging buffer and copied into the array during a timed write window that begins at the STOP ending the write. While that window runs, every control byte is refused, so a host can poll until the device answers. The window length is a parameter in system clock cycles, which lets a simulation use a short value.

The array depth is a parameter. Address bits above the array width alias onto the same cells. The clock line must stay in each phase for at least five system clocks. `WR_CYCLES` must be at least the page size.

Top module: `eep_i2c_target`

## Requirements
- R1: After reset `sda_pull_o` is 0 (line released) and no write window is running, so the first matching control byte is acknowledged.
- R2: A control byte is acknowledged (SDA pulled low during the ninth clock) only if its bits 7:4 equal 1010 and its bit 3 equals `hw_sel_i`. Otherwise SDA stays released for every later byte of that transaction until the next START, and nothing is staged.
- R3: The byte address is built from control byte bits 2:1 (address bits 17:16), then the first offset byte (15:8), then the second (7:0). The array is indexed by the low `MEM_AW` bits, so higher bits alias.
- R4: Every write data byte is acknowledged and stored at the pointer. The low 8 bits of the pointer then increment and wrap inside the current 256-byte page, so the next page is never touched.
- R5: A STOP that ends a write carrying at least one data byte starts a write window of `WR_CYCLES` clocks. During the window every control byte is NACKed. A write carrying only the offset, or a read, starts no window.
- R6: After the window, the written bytes read back, and bytes of the same page that were not written keep their previous contents.
- R7: Random read: an offset-only write, then a repeated START and a read control byte, returns data starting at the newly loaded address.
- R8: Sequential read: bytes go out MSB first, and the pointer advances by one after each byte, crossing page boundaries. Reading continues while the host acknowledges. A host NACK ends the read and leaves SDA released.
- R9: A read control byte with no preceding offset starts at the pointer left by the previous access, with address bits 17:16 taken from control byte bits 2:1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| hw_sel_i | input | 1 | Strap compared with address bit 18 |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The end of the write window and the acknowledge decision for a control byte can land in the same system clock. That clock decides whether a polling host is refused or accepted. The bench provokes this with acknowledge polling after every write, sweeping successive poll decisions across the expiry. It judges each poll by its distance from the STOP: polls well inside the window must be NACKed, polls well past it must be acknowledged, and the data read afterwards must match the bench's model, so the copy into the array has completed.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam int         PTR_W    = 18;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CTRL,
    PH_OFFH,
    PH_OFFL,
    PH_WDATA,
    PH_READ
  } phase_t;
endpackage

// File: rtl/eep_line_sampler.sv
module eep_line_sampler #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [SYNC-1:0] scl_q, sda_q;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC-2:0], scl_i};
      sda_q <= {sda_q[SYNC-2:0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_s    = scl_q[SYNC-1];
  assign sda_s    = sda_q[SYNC-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int MEM_AW    = 10,
  parameter int PAGE_AW   = 8,
  parameter int WR_CYCLES = 1000000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [MEM_AW-1:0]         rd_addr,
  output logic [7:0]                rd_data,
  input  logic                      page_ld,
  input  logic [MEM_AW-PAGE_AW-1:0] page_sel,
  input  logic                      stage_we,
  input  logic [PAGE_AW-1:0]        stage_idx,
  input  logic [7:0]                stage_data,
  input  logic                      launch,
  output logic                      busy
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam int PAGE  = 1 << PAGE_AW;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic [7:0]                mem  [DEPTH];
  logic [7:0]                pbuf [PAGE];
  logic [PAGE-1:0]           pvalid;
  logic [MEM_AW-PAGE_AW-1:0] page_q;
  logic [CNT_W-1:0]          cnt;
  logic                      busy_q;
  logic                      commit_en;
  logic [PAGE_AW-1:0]        cidx;

  assign busy      = busy_q;
  assign rd_data   = mem[rd_addr];
  assign cidx      = cnt[PAGE_AW-1:0];
  // Copy-out runs through the last PAGE clocks of the window.
  assign commit_en = busy_q && (cnt < CNT_W'(PAGE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt    <= '0;
      page_q <= '0;
    end else begin
      if (page_ld) page_q <= page_sel;
      if (launch && !busy_q) begin
        busy_q <= 1'b1;
        cnt    <= CNT_W'(WR_CYCLES - 1);
      end else if (busy_q) begin
        if (cnt == '0) busy_q <= 1'b0;
        else           cnt    <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pvalid <= '0;
    else if (stage_we) pvalid[stage_idx] <= 1'b1;
    else if (commit_en) pvalid[cidx] <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (stage_we) pbuf[stage_idx] <= stage_data;
  end

  always_ff @(posedge clk) begin
    if (commit_en && pvalid[cidx]) mem[{page_q, cidx}] <= pbuf[cidx];
  end

  // R6: staging never overlaps the copy-out window
  a_r6_stage_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stage_we |-> !busy_q);
  // R5: a new window is only requested while none runs
  a_r5_launch_idle: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !busy_q);
endmodule

// File: rtl/eep_i2c_target.sv
module eep_i2c_target #(
  parameter int MEM_AW    = 10,
  parameter int PAGE_AW   = 8,
  parameter int WR_CYCLES = 1000000,
  parameter int SYNC      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic hw_sel_i,
  output logic sda_pull_o
);
  import eep_pkg::*;

  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev, busy;
  logic [7:0] rd_data;

  phase_t           ph;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg, off_hi, txbyte;
  logic [1:0]       ctrl_hi;
  logic [PTR_W-1:0] ptr, new_off;
  logic             in_ack, drive, m_nack, dirty;
  logic             byte_done, ctrl_match;

  eep_line_sampler #(.SYNC(SYNC)) u_smp (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  assign new_off    = {ctrl_hi, off_hi, shreg};
  assign byte_done  = scl_fall && !in_ack && (bitcnt == 4'd8) &&
                      (ph inside {PH_CTRL, PH_OFFH, PH_OFFL, PH_WDATA});
  assign ctrl_match = (shreg[7:4] == DEV_TYPE) && (shreg[3] == hw_sel_i) && !busy;

  eep_store #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW), .WR_CYCLES(WR_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(ptr[MEM_AW-1:0]), .rd_data(rd_data),
    .page_ld(byte_done && ph == PH_OFFL),
    .page_sel(new_off[MEM_AW-1:PAGE_AW]),
    .stage_we(byte_done && ph == PH_WDATA),
    .stage_idx(ptr[PAGE_AW-1:0]), .stage_data(shreg),
    .launch(stop_ev && dirty), .busy(busy)
  );

  assign sda_pull_o = drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      off_hi  <= '0;
      txbyte  <= '0;
      ctrl_hi <= '0;
      ptr     <= '0;
      in_ack  <= 1'b0;
      drive   <= 1'b0;
      m_nack  <= 1'b0;
      dirty   <= 1'b0;
    end else if (start_ev) begin
      ph     <= PH_CTRL;
      bitcnt <= '0;
      in_ack <= 1'b0;
      drive  <= 1'b0;
    end else if (stop_ev) begin
      ph     <= PH_IDLE;
      bitcnt <= '0;
      in_ack <= 1'b0;
      drive  <= 1'b0;
      dirty  <= 1'b0;
    end else if (ph == PH_READ) begin
      if (scl_rise && in_ack) m_nack <= sda_s;
      if (scl_fall) begin
        if (in_ack) begin
          in_ack <= 1'b0;
          if (m_nack) begin
            ph    <= PH_IDLE;
            drive <= 1'b0;
          end else begin
            txbyte <= rd_data;
            ptr    <= ptr + 1'b1;
            drive  <= ~rd_data[7];
            bitcnt <= 4'd1;
          end
        end else if (bitcnt == 4'd8) begin
          drive  <= 1'b0;
          in_ack <= 1'b1;
        end else begin
          drive  <= ~txbyte[3'(4'd7 - bitcnt)];
          bitcnt <= bitcnt + 1'b1;
        end
      end
    end else if (ph != PH_IDLE) begin
      if (scl_rise && !in_ack && bitcnt < 4'd8) begin
        shreg  <= {shreg[6:0], sda_s};
        bitcnt <= bitcnt + 1'b1;
      end
      if (scl_fall && in_ack) begin
        in_ack <= 1'b0;
        drive  <= 1'b0;
        bitcnt <= '0;
      end else if (byte_done) begin
        case (ph)
          PH_CTRL: begin
            if (ctrl_match) begin
              in_ack <= 1'b1;
              drive  <= 1'b1;
              if (shreg[0]) begin
                ph         <= PH_READ;
                ptr[17:16] <= shreg[2:1];
                m_nack     <= 1'b0;
              end else begin
                ph      <= PH_OFFH;
                ctrl_hi <= shreg[2:1];
              end
            end else begin
              ph    <= PH_IDLE;
              drive <= 1'b0;
            end
          end
          PH_OFFH: begin
            off_hi <= shreg;
            ph     <= PH_OFFL;
            in_ack <= 1'b1;
            drive  <= 1'b1;
          end
          PH_OFFL: begin
            ptr    <= new_off;
            ph     <= PH_WDATA;
            in_ack <= 1'b1;
            drive  <= 1'b1;
          end
          default: begin
            ptr[PAGE_AW-1:0] <= ptr[PAGE_AW-1:0] + 1'b1;
            dirty  <= 1'b1;
            in_ack <= 1'b1;
            drive  <= 1'b1;
          end
        endcase
      end
    end
  end

  // R2: a foreign device type is never acknowledged
  a_r2_foreign_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && ph == PH_CTRL && shreg[7:4] != DEV_TYPE) |=> !sda_pull_o);
  // R5: control bytes arriving inside the write window are refused
  a_r5_busy_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && ph == PH_CTRL && busy) |=> !sda_pull_o);
  // R5: the window only opens on a STOP
  a_r5_busy_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_ev));
  // R4: every completed write data byte is acknowledged
  a_r4_data_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && ph == PH_WDATA) |=> sda_pull_o);
  // R8: SDA only moves after SCL falls or on START/STOP
  a_r8_sda_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_fall || start_ev || stop_ev) |=> $stable(sda_pull_o));
endmodule

// File: tb/tb_eep_i2c_target.sv
module tb_eep_i2c_target;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 6;
  localparam int WR         = 300;
  localparam int MEM_AW     = 10;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic dut_pull, sda;
  int   n_chk = 0, n_fail = 0, cyc = 0, stop_cyc = 0, ack_cyc = 0;

  logic [7:0]  mem_m [1 << MEM_AW];
  logic        known [1 << MEM_AW];
  logic [7:0]  wbuf  [64];
  logic [17:0] ptr_m;

  assign sda = sda_m & ~dut_pull;

  eep_i2c_target #(.MEM_AW(MEM_AW), .PAGE_AW(8), .WR_CYCLES(WR), .SYNC(2)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .hw_sel_i(1'b1), .sda_pull_o(dut_pull)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] ctrl_byte(input logic [1:0] hi, input logic rd);
    return {4'b1010, 1'b1, hi, rd};
  endfunction

  function automatic int midx(input logic [17:0] a);
    return int'(a[MEM_AW-1:0]);
  endfunction

  function automatic logic [17:0] wr_addr(input logic [17:0] base, input int i);
    return {base[17:8], base[7:0] + 8'(i)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hc(H); scl = 1'b1; hc(H); sda_m = 1'b0; hc(H); scl = 1'b0; hc(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hc(H); scl = 1'b1; hc(H); sda_m = 1'b1; stop_cyc = cyc; hc(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hc(H); scl = 1'b1; hc(H); scl = 1'b0; hc(2);
    end
    sda_m = 1'b1; hc(H); scl = 1'b1; hc(H/2);
    ack = ~sda; ack_cyc = cyc;
    hc(H/2); scl = 1'b0; hc(2);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hc(H); scl = 1'b1; hc(H/2); b[i] = sda; hc(H/2); scl = 1'b0; hc(2);
    end
    sda_m = nack; hc(H); scl = 1'b1; hc(H); scl = 1'b0; hc(2);
  endtask

  // Acknowledge polling after a write; judges each poll against its distance from STOP.
  task automatic wait_ready();
    int   t0 = stop_cyc;
    logic ack = 1'b0;
    for (int k = 0; k < 40 && !ack; k++) begin
      bus_start();
      send_byte(ctrl_byte(2'b00, 1'b0), ack);
      if (ack_cyc - t0 <= WR) chk(!ack, "R5 poll inside window", int'(ack), 0);
      if (ack_cyc - t0 >= WR + 30) chk(ack, "R5 poll after window", int'(ack), 1);
      bus_stop();
    end
    chk(ack, "R5 device ready", int'(ack), 1);
  endtask

  task automatic do_write(input logic [17:0] addr, input int n);
    logic ack;
    bus_start();
    send_byte(ctrl_byte(addr[17:16], 1'b0), ack); chk(ack, "R2 ctrl ack", int'(ack), 1);
    send_byte(addr[15:8], ack); chk(ack, "R3 offset hi ack", int'(ack), 1);
    send_byte(addr[7:0], ack);  chk(ack, "R3 offset lo ack", int'(ack), 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);
      chk(ack, "R4 data ack", int'(ack), 1);
      mem_m[midx(wr_addr(addr, i))] = wbuf[i];
      known[midx(wr_addr(addr, i))] = 1'b1;
    end
    bus_stop();
    ptr_m = wr_addr(addr, n);
    if (n > 0) wait_ready();
  endtask

  task automatic do_read(input logic [17:0] addr, input int n, input string req);
    logic ack;
    logic [7:0] b;
    bus_start();
    send_byte(ctrl_byte(addr[17:16], 1'b0), ack);
    send_byte(addr[15:8], ack);
    send_byte(addr[7:0], ack);
    bus_start();
    send_byte(ctrl_byte(addr[17:16], 1'b1), ack); chk(ack, "R7 read ctrl ack", int'(ack), 1);
    for (int i = 0; i < n; i++) begin
      logic [17:0] a = addr + 18'(i);
      recv_byte(i == n - 1, b);
      if (known[midx(a)]) chk(b == mem_m[midx(a)], req, int'(b), int'(mem_m[midx(a)]));
    end
    hc(4);
    chk(dut_pull == 1'b0, "R8 released after NACK", int'(dut_pull), 0);
    bus_stop();
    ptr_m = addr + 18'(n);
  endtask

  task automatic cur_read(input logic [1:0] hi);
    logic ack;
    logic [7:0] b;
    logic [17:0] a = {hi, ptr_m[15:0]};
    bus_start();
    send_byte(ctrl_byte(hi, 1'b1), ack); chk(ack, "R9 ctrl ack", int'(ack), 1);
    recv_byte(1'b1, b);
    if (known[midx(a)]) chk(b == mem_m[midx(a)], "R9 current address", int'(b), int'(mem_m[midx(a)]));
    bus_stop();
    ptr_m = a + 18'd1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=<190000", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic ack;
    int   r;
    for (int i = 0; i < (1 << MEM_AW); i++) known[i] = 1'b0;
    r = $urandom(32'h5EED);
    hc(10);
    chk(dut_pull == 1'b0, "R1 released in reset", int'(dut_pull), 0);
    rst_n = 1'b1; hc(5);
    chk(dut_pull == 1'b0, "R1 released after reset", int'(dut_pull), 0);
    bus_start(); send_byte(ctrl_byte(2'b00, 1'b0), ack);
    chk(ack, "R1 no window after reset", int'(ack), 1); bus_stop();

    // two neighbouring pages, then a read across their boundary
    for (int i = 0; i < 16; i++) wbuf[i] = 8'(8'h30 + i);
    do_write(18'h001F0, 16);
    for (int i = 0; i < 16; i++) wbuf[i] = 8'(8'hC0 + i);
    do_write(18'h00200, 16);
    do_read(18'h001FC, 8, "R8 sequential across page");
    cur_read(2'b00);

    // wrap within page 0; byte 0x100 must not be hit
    wbuf[0] = 8'h5A; do_write(18'h00100, 1);
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    do_write(18'h000FE, 4);
    do_read(18'h00000, 2, "R4 wrapped bytes");
    do_read(18'h000FE, 3, "R4 no spill to next page");

    // partial page rewrite keeps neighbours
    wbuf[0] = 8'hE1; wbuf[1] = 8'hE2; do_write(18'h001F4, 2);
    do_read(18'h001F0, 8, "R6 partial page");

    // high address bits alias onto the array
    do_read(18'h101F0, 4, "R3 alias of bits 17:16");

    // foreign device type, then wrong strap bit
    bus_start();
    send_byte(8'b1011_1_00_0, ack); chk(!ack, "R2 foreign type", int'(ack), 0);
    send_byte(8'h01, ack);          chk(!ack, "R2 later byte released", int'(ack), 0);
    send_byte(8'hF0, ack);          chk(!ack, "R2 later byte released", int'(ack), 0);
    bus_stop();
    bus_start();
    send_byte(8'b1010_0_00_0, ack); chk(!ack, "R2 strap mismatch", int'(ack), 0);
    send_byte(8'hAA, ack);          chk(!ack, "R2 strap mismatch data", int'(ack), 0);
    bus_stop();
    bus_start(); send_byte(ctrl_byte(2'b00, 1'b0), ack);
    chk(ack, "R2 nothing staged", int'(ack), 1); bus_stop();

    // offset only: no window, current read from new pointer
    do_write(18'h001F2, 0);
    bus_start(); send_byte(ctrl_byte(2'b00, 1'b0), ack);
    chk(ack, "R5 offset-only starts no window", int'(ack), 1); bus_stop();
    ptr_m = 18'h001F2;
    cur_read(2'b00);

    // random traffic
    for (int t = 0; t < 8; t++) begin
      logic [17:0] a;
      int n;
      a = 18'($urandom);
      n = 1 + int'($urandom % 12);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      do_write(a, n);
      do_read(wr_addr(a, int'($urandom % 4)), 1 + int'($urandom % 8), "R7 random read");
      cur_read(a[17:16]);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule